// File: doc/BRIEF.md
# Real-time clock with counter hold and carry-busy handshake

This block keeps time of day in three counters (seconds, minutes, hours) advanced by a sub-second prescaler. The prescaler counts pulses of a 32768 Hz tick enable. Each time it rolls over, one second is added, and a carry window of a fixed number of ticks begins. During that window the higher counters are treated as unstable.

Software reaches the block through a small register port. It sets a hold bit and then reads a busy flag. Busy at 0 means no carry is in flight, so the time counters can be read or written safely. While hold is set, the prescaler keeps running. If it rolls over during the hold, the block adds the missed second itself and drops the hold, so software learns that its access window has closed.

The read port is combinational over registered state. Writes and rollovers take effect at the clock edge that samples them.

Top module: `rtcHoldCore`

## Requirements
- R1: After reset the hold bit and the seconds, minutes, hours and prescaler counters are 0, and the control register (address 0) reads 0x2.
- R2: Control register bit 0 is the hold bit, which can be read and written. Bit 1 is the busy flag, which is read-only, and writing it has no effect. Bits 31:2 read 0. Addresses 1, 2 and 3 read seconds, minutes and hours in bits 5:0, with all other bits 0.
- R3: While hold is 0 the busy flag reads 1.
- R4: The prescaler advances only on edges where tickEn is 1. The edge on which it completes SUBSEC_TICKS ticks is a rollover, and a rollover adds one second.
- R5: With hold at 1, busy reads 1 during the CARRY_TICKS ticks that follow each rollover and 0 at other times.
- R6: A write to address 1, 2 or 3 stores regWdata[5:0] only when hold is 1 and busy is 0. Any other such write leaves the counter unchanged.
- R7: Seconds and minutes step from 59 (or any value at or above it) to 0 and carry into the next counter. Hours step from 23 to 0.
- R8: A rollover while hold is 1 still adds exactly one second, and on the same edge hold returns to 0.
- R9: When a rollover and an accepted time write share an edge, the one-second increment, including any carries, is applied on top of the written value.
- R10: Holding does not pause the prescaler. Rollovers keep their spacing of SUBSEC_TICKS ticks whatever the hold bit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle pulse per 32768 Hz tick |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 seconds, 2 minutes, 3 hours |
| regWdata | input | 6 | Write data |
| regRdata | output | 32 | Read data for regAddr |

## Verification
Every result lands on the edge that samples its cause. A write, a rollover, a hold drop or a window reload is visible on regRdata in the cycle that follows that edge. Busy flips on the edge of the tick that ends the window. The bench therefore changes inputs just after a rising edge and samples regRdata at the falling edge of the same cycle, where every registered effect of the previous edge has settled. A behavioural reference model advances on the same rising edges and is compared at every falling edge. Directed checks with literal expected values cover the wraps, the same-edge write and rollover, and the automatic hold release.

// File: rtl/rtc_hold_pkg.sv
package rtc_hold_pkg;
  localparam int FIELD_N = 3;   // seconds, minutes, hours
  localparam int TIME_W  = 6;
  localparam logic [1:0] ADDR_CTRL = 2'd0;

  typedef struct packed {
    logic               incSec;   // rollover: add one second
    logic [FIELD_N-1:0] wrField;  // accepted write per field
  } timeStrobe_t;
endpackage

// File: rtl/rtcHoldCtrl.sv
module rtcHoldCtrl
  import rtc_hold_pkg::*;
#(
  parameter int SUBSEC_TICKS = 32768,
  parameter int CARRY_TICKS  = 131,
  localparam int SUB_W = $clog2(SUBSEC_TICKS),
  localparam int WIN_W = $clog2(CARRY_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic             holdWrBit,
  output logic             holdQ,
  output logic             busy,
  output logic             rollover,
  output logic [SUB_W-1:0] subCnt,
  output timeStrobe_t      strb
);
  logic [WIN_W-1:0] winCnt;
  logic             winActive;
  logic             wrOk;

  assign rollover  = tickEn && (subCnt == SUB_W'(SUBSEC_TICKS - 1));
  assign winActive = (winCnt != '0);
  assign busy      = !holdQ || winActive;
  assign wrOk      = holdQ && !winActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      subCnt <= '0;
    end else if (rollover) begin
      subCnt <= '0;
    end else if (tickEn) begin
      subCnt <= subCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt <= '0;
    end else if (rollover) begin
      winCnt <= WIN_W'(CARRY_TICKS);
    end else if (tickEn && winActive) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ <= 1'b0;
    end else if (rollover && holdQ) begin
      holdQ <= 1'b0;
    end else if (regWr && regAddr == ADDR_CTRL) begin
      holdQ <= holdWrBit;
    end
  end

  always_comb begin
    strb.incSec = rollover;
    for (int i = 0; i < FIELD_N; i++) begin
      strb.wrField[i] = regWr && wrOk && (regAddr == 2'(i + 1));
    end
  end
endmodule

// File: rtl/rtcTimeDp.sv
module rtcTimeDp
  import rtc_hold_pkg::*;
#(
  parameter int SEC_MOD  = 60,
  parameter int MIN_MOD  = 60,
  parameter int HOUR_MOD = 24
) (
  input  logic                            clk,
  input  logic                            rst,
  input  timeStrobe_t                     strb,
  input  logic [TIME_W-1:0]               wrValue,
  output logic [FIELD_N-1:0][TIME_W-1:0]  fieldQ
);
  logic [FIELD_N-1:0] carry;

  assign carry[0] = strb.incSec;

  for (genvar gi = 0; gi < FIELD_N; gi++) begin : g_field
    localparam int LIM = (gi == 0) ? SEC_MOD : (gi == 1) ? MIN_MOD : HOUR_MOD;
    logic [TIME_W-1:0] base;
    logic [TIME_W-1:0] q;
    logic              atTop;

    assign base  = strb.wrField[gi] ? wrValue : q;
    assign atTop = (base >= TIME_W'(LIM - 1));

    if (gi < FIELD_N - 1) begin : g_next
      assign carry[gi+1] = carry[gi] && atTop;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (carry[gi]) begin
        q <= atTop ? '0 : base + 1'b1;
      end else begin
        q <= base;
      end
    end

    assign fieldQ[gi] = q;
  end
endmodule

// File: rtl/rtcHoldCore.sv
module rtcHoldCore
  import rtc_hold_pkg::*;
#(
  parameter int SUBSEC_TICKS = 32768,
  parameter int CARRY_TICKS  = 131,
  localparam int SUB_W = $clog2(SUBSEC_TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [TIME_W-1:0] regWdata,
  output logic [31:0]       regRdata
);
  timeStrobe_t                    strb;
  logic                           holdQ;
  logic                           busy;
  logic                           rollover;
  logic [SUB_W-1:0]               subCnt;
  logic [FIELD_N-1:0][TIME_W-1:0] fieldQ;

  rtcHoldCtrl #(
    .SUBSEC_TICKS(SUBSEC_TICKS),
    .CARRY_TICKS (CARRY_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .holdWrBit(regWdata[0]),
    .holdQ    (holdQ),
    .busy     (busy),
    .rollover (rollover),
    .subCnt   (subCnt),
    .strb     (strb)
  );

  rtcTimeDp u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .wrValue(regWdata),
    .fieldQ (fieldQ)
  );

  always_comb begin
    if (regAddr == ADDR_CTRL) begin
      regRdata = {30'b0, busy, holdQ};
    end else begin
      regRdata = {{(32 - TIME_W){1'b0}}, fieldQ[regAddr - 2'd1]};
    end
  end
endmodule

// File: rtl/rtcHoldCore_chk.sv
module rtcHoldCore_chk #(
  parameter int SUB_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             tickEn,
  input logic             regWr,
  input logic [1:0]       regAddr,
  input logic [31:0]      regRdata,
  input logic             holdQ,
  input logic             busy,
  input logic             rollover,
  input logic [SUB_W-1:0] subCnt,
  input logic [5:0]       secQ,
  input logic [5:0]       minQ,
  input logic [5:0]       hourQ
);
  // R2
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd0) |-> (regRdata[31:2] == 30'b0));

  // R3
  busy_when_running_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd0 && !regRdata[0]) |-> regRdata[1]);

  // R4
  prescaler_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(subCnt));

  // R6
  busy_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (regWr && regAddr == 2'd1 && busy && !rollover) |=> $stable(secQ));

  // R7
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (rollover && !regWr && secQ == 6'd59 && minQ == 6'd59 && hourQ == 6'd23)
    |=> (secQ == 6'd0 && minQ == 6'd0 && hourQ == 6'd0));

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rollover && holdQ) |=> !holdQ);
endmodule

bind rtcHoldCore rtcHoldCore_chk #(.SUB_W(SUB_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tickEn  (tickEn),
  .regWr   (regWr),
  .regAddr (regAddr),
  .regRdata(regRdata),
  .holdQ   (holdQ),
  .busy    (busy),
  .rollover(rollover),
  .subCnt  (subCnt),
  .secQ    (fieldQ[0]),
  .minQ    (fieldQ[1]),
  .hourQ   (fieldQ[2])
);

// File: tb/rtcHoldCore_tb.sv
`timescale 1ns/1ps
module rtcHoldCore_tb;
  localparam int SUB   = 20;
  localparam int CARRY = 4;
  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [5:0]  regWdata = 6'd0;
  logic [31:0] regRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  // behavioural reference model
  int mSub = 0, mWin = 0, mSec = 0, mMin = 0, mHour = 0;
  bit mHold = 1'b0;

  always #10 clk = ~clk;

  rtcHoldCore #(.SUBSEC_TICKS(SUB), .CARRY_TICKS(CARRY)) u_dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      mSub = 0; mWin = 0; mSec = 0; mMin = 0; mHour = 0; mHold = 0;
    end else begin
      bit roll;
      bit okWr;
      bit oldHold;
      roll    = tickEn && (mSub == SUB - 1);
      okWr    = mHold && (mWin == 0);
      oldHold = mHold;
      if (regWr && okWr) begin
        case (regAddr)
          2'd1: mSec  = int'(regWdata);
          2'd2: mMin  = int'(regWdata);
          2'd3: mHour = int'(regWdata);
          default: ;
        endcase
      end
      if (regWr && regAddr == 2'd0) mHold = regWdata[0];
      if (roll) begin
        if (oldHold) mHold = 0;
        if (mSec >= 59) begin
          mSec = 0;
          if (mMin >= 59) begin
            mMin = 0;
            mHour = (mHour >= 23) ? 0 : mHour + 1;
          end else mMin = mMin + 1;
        end else mSec = mSec + 1;
        mSub = 0;
        mWin = CARRY;
      end else if (tickEn) begin
        mSub = mSub + 1;
        if (mWin > 0) mWin = mWin - 1;
      end
    end
  end

  function automatic logic [31:0] mRead(logic [1:0] a);
    case (a)
      2'd0: return {30'b0, (!mHold || mWin > 0), mHold};
      2'd1: return 32'(mSec);
      2'd2: return 32'(mMin);
      default: return 32'(mHour);
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2..R10 through the read port)
  always @(negedge clk) begin
    if (live && !rst && !done)
      check(regAddr == 2'd0 ? "R5 model ctrl" : "R4 model time", regRdata, mRead(regAddr));
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrReg(logic [1:0] a, logic [5:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    step();
    regWr = 1'b0;
  endtask

  task automatic rdCheck(logic [1:0] a, logic [31:0] exp, string tag);
    regAddr = a;
    @(negedge clk);
    check(tag, regRdata, exp);
    step();
  endtask

  task automatic waitSub(int v);
    while (mSub != v) step();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int s0;
    repeat (3) step();
    rst = 1'b0;
    live = 1'b1;
    // R1 / R3: reset state, tick held low
    rdCheck(2'd0, 32'h2, "R1 ctrl after reset");
    rdCheck(2'd1, 32'h0, "R1 seconds");
    rdCheck(2'd2, 32'h0, "R1 minutes");
    rdCheck(2'd3, 32'h0, "R1 hours");
    rdCheck(2'd0, 32'h2, "R3 busy while running");

    // R4: free run, then gated ticks
    tickEn = 1'b1;
    for (int i = 0; i < 50; i++) begin regAddr = 2'(i); step(); end
    rdCheck(2'd1, 32'd2, "R4 two rollovers after 50 ticks");
    for (int i = 0; i < 90; i++) begin tickEn = (i % 3 == 0); regAddr = 2'(i); step(); end
    tickEn = 1'b1;

    // R2: busy bit not writable
    wrReg(2'd0, 6'h3E);
    rdCheck(2'd0, 32'h2, "R2 busy write ignored");

    // R5 / R6: hold inside carry window
    waitSub(SUB - 1);
    step();                     // rollover edge
    s0 = mSec;
    wrReg(2'd0, 6'd1);
    rdCheck(2'd0, 32'h3, "R5 busy inside window");
    wrReg(2'd1, 6'd30);
    rdCheck(2'd1, 32'(s0), "R6 write during busy ignored");
    repeat (4) step();
    rdCheck(2'd0, 32'h1, "R5 not busy after window");
    wrReg(2'd1, 6'd59);
    wrReg(2'd2, 6'd59);
    wrReg(2'd3, 6'd23);
    rdCheck(2'd1, 32'd59, "R6 accepted write");
    wrReg(2'd0, 6'd0);
    waitSub(SUB - 1);
    step();
    rdCheck(2'd1, 32'd0, "R7 seconds wrap");
    rdCheck(2'd2, 32'd0, "R7 minutes wrap");
    rdCheck(2'd3, 32'd0, "R7 hours wrap");

    // R6: write with hold clear ignored
    s0 = mSec;
    wrReg(2'd1, 6'd33);
    rdCheck(2'd1, 32'(s0), "R6 write without hold ignored");

    // R8 / R10: rollover under hold
    waitSub(CARRY + 2);
    wrReg(2'd0, 6'd1);
    rdCheck(2'd0, 32'h1, "R5 held and idle");
    s0 = mSec;
    waitSub(SUB - 1);
    step();
    rdCheck(2'd0, 32'h2, "R8 hold released");
    rdCheck(2'd1, 32'(s0 + 1), "R8 one second added");
    rdCheck(2'd0, 32'h2, "R10 prescaler kept rollover spacing");

    // R9: write on the rollover edge
    waitSub(CARRY + 2);
    wrReg(2'd0, 6'd1);
    waitSub(SUB - 1);
    wrReg(2'd1, 6'd10);
    rdCheck(2'd1, 32'd11, "R9 increment on written value");
    rdCheck(2'd0, 32'h2, "R8 hold cleared with write");
    waitSub(CARRY + 2);
    wrReg(2'd0, 6'd1);
    waitSub(SUB - 1);
    wrReg(2'd1, 6'd59);
    rdCheck(2'd1, 32'd0, "R9 written 59 wraps");
    rdCheck(2'd2, 32'd1, "R9 carry into minutes");

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      tickEn = (i % 5 != 2);
      regAddr = 2'(i * 7);
      regWr = (i % 37 == 0);
      regWdata = 6'(i);
      step();
    end
    regWr = 1'b0;
    finishRun();
  end
endmodule